// File: doc/BRIEF.md
# Circulant Block Sparse Matrix-Vector Multiplier over GF(2)

This block multiplies a vector by a fixed block-structured binary matrix, modulo 2. The matrix is split into square P×P blocks. Each block is either all zero or an identity matrix rotated right by a per-block amount. Because a rotated identity only re-orders the bits of its input, each output subvector is the XOR of its row's input subvectors, each read from a rotated starting address. The block shape, the rotation amounts and the offline time-slot schedule are all parameters.

Work proceeds in time slots. Within a slot, every output subvector assigned to that slot is produced in parallel, one bit per clock. Each input subvector lives in a single P-bit store with its own read counter. That counter is seeded with the rotation of the block it feeds in the current slot, so two rows that read the same input must sit in different slots. A full multiply therefore takes NSLOT·P cycles.

The input stores are double-buffered. The next vector can be written, one subvector per cycle, while the current one is being processed. A start pulse swaps the buffers and launches the run, and done pulses once the last slot finishes. Results stay readable, a whole subvector at a time, through a row-select read port.

Top module: `circ_spmv`

## Requirements
- R1: After reset, done is low, every output subvector reads zero, and both input buffers hold zero. A run started with no loads therefore yields all-zero results.
- R2: When a run finishes, bit j of output subvector r equals the XOR, over every column c with NZ bit r*NBC+c set, of bit (j+s) mod P of input subvector c. Here s is the field SHIFT[(r*NBC+c)*SW +: SW].
- R3: done is high for exactly one cycle. It rises NSLOT*P clock edges after the edge that accepts start.
- R4: Row r is computed in the slot given by SLOT[r*TW +: TW]. Slots run in ascending order from 0. Bit j of each active row is written in cycle j of its slot. Rows of other slots keep their previous contents until their own slot.
- R5: A start that arrives while a run is in progress is ignored. It does not restart the run, swap the buffers or change the timing of done.
- R6: A load (ld_en with column ld_col) writes into the buffer that is not being read by the current run, so it never changes the running result. The next accepted start uses that buffer. A load made in the same cycle as an accepted start becomes part of the vector being started.
- R7: A load whose column is NBC or above changes no stored data. A read with a row of NBR or above returns zero.
- R8: Once a run completes, the output subvectors keep their values until a later run writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write ld_data into the fill buffer this cycle |
| ld_col | input | CW | Input subvector (block column) being written |
| ld_data | input | P | Input subvector value |
| start | input | 1 | Swap buffers and begin a multiply (ignored while running) |
| done | output | 1 | One-cycle pulse when all slots have finished |
| rd_row | input | RW | Output subvector (block row) to read |
| rd_data | output | P | Selected output subvector |

## Verification
The multiplier is driven with the following input vectors:
- An all-zero vector, which shows whether reset left the buffers clean.
- A vector with a single set bit, which shows whether the rotation runs the right way and which rows pick up that column.
- An all-ones vector, which separates rows with an odd number of blocks from rows with an even number.
- Random vectors, which exercise every rotation at once.

A reference model in the bench tracks the output stores cycle by cycle while the read row sweeps every index, including out-of-range ones. This exposes rows written in the wrong slot or at the wrong bit address. Extra start pulses during a run, loads overlapping a run, a load in the start cycle and an out-of-range load column test the buffer-swap rules.

// File: rtl/circ_spmv.sv
module circ_spmv #(
  parameter int P     = 8,
  parameter int NBR   = 5,
  parameter int NBC   = 5,
  parameter int NSLOT = 3,
  parameter int SW    = (P > 1) ? $clog2(P) : 1,
  parameter int TW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  parameter int CW    = (NBC > 1) ? $clog2(NBC) : 1,
  parameter int RW    = (NBR > 1) ? $clog2(NBR) : 1,
  parameter logic [NBR*NBC-1:0]    NZ    = 25'b10110_11000_11011_01001_00111,
  parameter logic [NBR*NBC*SW-1:0] SHIFT = 75'o3517246025713640152736041,
  parameter logic [NBR*TW-1:0]     SLOT  = 10'b01_00_10_01_00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_col,
  input  logic [P-1:0]  ld_data,
  input  logic          start,
  output logic          done,
  input  logic [RW-1:0] rd_row,
  output logic [P-1:0]  rd_data
);

  function automatic logic [SW-1:0] shift_of(int r, int c);
    return SHIFT[(r*NBC+c)*SW +: SW];
  endfunction

  function automatic logic [TW-1:0] slot_of(int r);
    return SLOT[r*TW +: TW];
  endfunction

  logic [P-1:0]  xbuf [2][NBC];
  logic [P-1:0]  ybuf [NBR];
  logic [SW-1:0] rc   [NBC];
  logic          busy, cbank;
  logic [TW-1:0] slot, nslot;
  logic [SW-1:0] cnt;
  logic [NBC-1:0] colbit;
  logic [NBR-1:0] rowbit, rowact;
  logic accept, slot_end, last, seed;

  assign accept   = start && !busy;
  assign slot_end = busy && (cnt == SW'(P-1));
  assign last     = slot_end && (slot == TW'(NSLOT-1));
  assign seed     = accept || (slot_end && !last);
  assign nslot    = accept ? '0 : slot + 1'b1;

  for (genvar c = 0; c < NBC; c++) begin : g_col
    assign colbit[c] = xbuf[cbank][c][rc[c]];
  end

  for (genvar r = 0; r < NBR; r++) begin : g_row
    assign rowbit[r] = ^(colbit & NZ[r*NBC +: NBC]);
    assign rowact[r] = busy && (slot_of(r) == slot);
  end

  assign rd_data = (int'(rd_row) < NBR) ? ybuf[rd_row] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cbank <= 1'b0;
      slot  <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < NBC; c++) xbuf[b][c] <= '0;
      for (int r = 0; r < NBR; r++) ybuf[r] <= '0;
      for (int c = 0; c < NBC; c++) rc[c] <= '0;
    end else begin
      done <= last;
      if (ld_en && int'(ld_col) < NBC) xbuf[~cbank][ld_col] <= ld_data;

      if (accept) begin
        busy  <= 1'b1;
        cbank <= ~cbank;
        slot  <= '0;
        cnt   <= '0;
      end else if (busy) begin
        cnt <= slot_end ? '0 : cnt + 1'b1;
        if (slot_end) begin
          if (last) busy <= 1'b0;
          else      slot <= slot + 1'b1;
        end
      end

      for (int r = 0; r < NBR; r++)
        if (rowact[r]) ybuf[r][cnt] <= rowbit[r];

      for (int c = 0; c < NBC; c++) begin
        if (seed) begin
          rc[c] <= '0;
          for (int r = 0; r < NBR; r++)
            if (slot_of(r) == nslot && NZ[r*NBC+c]) rc[c] <= shift_of(r, c);
        end else if (busy) begin
          rc[c] <= (rc[c] == SW'(P-1)) ? '0 : rc[c] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/circ_spmv_chk.sv
module circ_spmv_chk #(
  parameter int P     = 8,
  parameter int NSLOT = 3,
  parameter int SW    = 3,
  parameter int TW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          busy,
  input logic          cbank,
  input logic [TW-1:0] slot,
  input logic [SW-1:0] cnt
);

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  a_r5_busy_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cbank));

  a_r5_idle_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy && slot == '0 && cnt == '0 && cbank != $past(cbank));

  a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot) < NSLOT);

  a_r4_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == SW'(P-1) && slot != TW'(NSLOT-1)) |=>
      busy && cnt == '0 && slot == $past(slot) + 1'b1);

  a_r3_run_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == SW'(P-1) && slot == TW'(NSLOT-1)) |=> done && !busy);

endmodule

bind circ_spmv circ_spmv_chk #(.P(P), .NSLOT(NSLOT), .SW(SW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .busy(busy), .cbank(cbank), .slot(slot), .cnt(cnt)
);

// File: tb/sim_circ_spmv.sv
`timescale 1ns/1ps
module sim_circ_spmv;
  localparam int P = 8, NBR = 5, NBC = 5, NSLOT = 3, SW = 3, TW = 2, CW = 3, RW = 3;
  localparam logic [NBR*NBC-1:0]    NZ    = 25'b10110_11000_11011_01001_00111;
  localparam logic [NBR*NBC*SW-1:0] SHIFT = 75'o3517246025713640152736041;
  localparam logic [NBR*TW-1:0]     SLOT  = 10'b01_00_10_01_00;

  logic clk = 0, rst_n = 0, ld_en = 0, start = 0, done;
  logic [CW-1:0] ld_col = '0;
  logic [P-1:0]  ld_data = '0, rd_data;
  logic [RW-1:0] rd_row = '0;
  int total = 0, bad = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  circ_spmv #(.P(P), .NBR(NBR), .NBC(NBC), .NSLOT(NSLOT),
              .NZ(NZ), .SHIFT(SHIFT), .SLOT(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_col(ld_col), .ld_data(ld_data),
    .start(start), .done(done), .rd_row(rd_row), .rd_data(rd_data));

  logic [P-1:0] mx [2][NBC];
  logic [P-1:0] my [NBR];
  int mbusy = 0, mbank = 0, mslot = 0, mj = 0, mdone = 0, ob, okb;
  logic b;
  logic [P-1:0] exp_rd;

  function automatic int shv(int r, int c); return int'(SHIFT[(r*NBC+c)*SW +: SW]); endfunction
  function automatic int slv(int r); return int'(SLOT[r*TW +: TW]); endfunction

  task automatic check(string t, logic [P-1:0] got, logic [P-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) for (int c = 0; c < NBC; c++) mx[k][c] = '0;
      for (int r = 0; r < NBR; r++) my[r] = '0;
      mbusy = 0; mbank = 0; mslot = 0; mj = 0; mdone = 0;
    end else begin
      ob = mbusy; okb = mbank; mdone = 0;
      if (ob != 0) begin
        for (int r = 0; r < NBR; r++) if (slv(r) == mslot) begin
          b = 1'b0;
          for (int c = 0; c < NBC; c++)
            if (NZ[r*NBC+c]) b = b ^ mx[okb][c][(mj + shv(r, c)) % P];
          my[r][mj] = b;
        end
        if (mj == P-1) begin
          mj = 0;
          if (mslot == NSLOT-1) begin mbusy = 0; mdone = 1; end
          else mslot++;
        end else mj++;
      end
      if (ld_en && int'(ld_col) < NBC) mx[1-okb][ld_col] = ld_data;
      if (start && ob == 0) begin mbank = 1 - okb; mbusy = 1; mslot = 0; mj = 0; end
    end
    #1;
    check("R3 done", {7'd0, done}, P'(mdone));
    exp_rd = (int'(rd_row) < NBR) ? my[rd_row] : '0;
    check(tag, rd_data, exp_rd);
  end

  task automatic load(int col, logic [P-1:0] v);
    ld_en = 1; ld_col = CW'(col); ld_data = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic load_vec(logic [P-1:0] v0, logic [P-1:0] v1, logic [P-1:0] v2,
                          logic [P-1:0] v3, logic [P-1:0] v4);
    load(0, v0); load(1, v1); load(2, v2); load(3, v3); load(4, v4);
  endtask

  // extra_start: pulse start mid-run (R5); next_load: load column 4 during run (R6)
  task automatic run(bit extra_start, bit next_load, logic [P-1:0] nv);
    int k;
    start = 1;
    @(negedge clk);
    start = 0; k = 0;
    while (!done && k < 1000) begin
      rd_row = RW'(k % 8);
      if (extra_start && k == 5) start = 1;
      if (extra_start && k == 9) start = 1;
      if (next_load && k == 3) begin ld_en = 1; ld_col = 3'd4; ld_data = nv; end
      @(negedge clk);
      start = 0; ld_en = 0;
      k++;
    end
    total++;
    if (k != NSLOT*P) begin
      bad++;
      $display("FAIL R3 latency: got %0d expected %0d", k, NSLOT*P);
    end
    @(negedge clk);
    check("R3 pulse width", {7'd0, done}, '0);
  endtask

  task automatic read_all(string t);
    for (int r = 0; r < 8; r++) begin
      rd_row = RW'(r);
      #1;
      check(t, rd_data, (r < NBR) ? my[r] : '0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8*150000);
    bad++; total++;
    $display("FAIL R3 watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    for (int r = 0; r < NBR; r++) begin
      rd_row = RW'(r); #1;
      check("R1 reset read", rd_data, '0);
    end
    total++;
    if (done !== 1'b0) begin bad++; $display("FAIL R1 done: got %b expected 0", done); end
    rst_n = 1;
    @(negedge clk);
    tag = "R1 zero run";
    run(0, 0, '0);
    read_all("R1 zero result");

    tag = "R2 single bit";
    load_vec(8'h00, 8'h00, 8'h01, 8'h00, 8'h00);
    run(0, 0, '0);
    read_all("R2 single bit result");

    tag = "R2 all ones";
    load_vec(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    run(0, 0, '0);
    read_all("R2 all ones result");

    tag = "R4 slot order";
    load_vec(P'($urandom), P'($urandom), P'($urandom), P'($urandom), P'($urandom));
    run(0, 0, '0);
    read_all("R8 hold after done");
    repeat (4) @(negedge clk);
    read_all("R8 hold idle");

    tag = "R5 start while running";
    load_vec(P'($urandom), P'($urandom), P'($urandom), P'($urandom), P'($urandom));
    run(1, 0, '0);
    read_all("R5 result");

    tag = "R6 overlap load";
    load_vec(8'h5A, 8'h3C, 8'h81, 8'h00, 8'h00);
    load(3, 8'h77);
    ld_en = 1; ld_col = 3'd4; ld_data = 8'hE1;
    run(0, 1, 8'h96);
    read_all("R6 first result");
    run(0, 0, '0);
    read_all("R6 second result");

    tag = "R7 bad column";
    load_vec(8'h12, 8'h34, 8'h56, 8'h78, 8'h9A);
    load(6, 8'hFF);
    load(5, 8'hAA);
    run(0, 0, '0);
    read_all("R7 result");

    for (int n = 0; n < 4; n++) begin
      tag = "R2 random";
      load_vec(P'($urandom), P'($urandom), P'($urandom), P'($urandom), P'($urandom));
      run(0, 0, '0);
      read_all("R2 random result");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule